// File: doc/BRIEF.md
# Real-Time Clock Register Bank with Interrupt Flags

This block is the software-visible face of a real-time clock. It holds 128 byte locations behind a two-address port: a write to the even address picks a location, and reads and writes to the odd address then reach that location. Fourteen low locations have fixed meanings: three time bytes, three alarm bytes, four date bytes and four control/status registers (A to D). Every location above them is plain byte storage.

The calendar counter and the periodic rate generator are separate blocks. They report to this bank through three strobes: update-begin, update-end and periodic tick. They also present the current second, minute and hour for the alarm compare. In return the bank exposes registers A and B so those neighbours can read their rate and mode settings.

The bank turns the strobes into flags in register C, gated by the enable bits in register B. It drives a single active-high, registered interrupt line. A read of register C returns the flags, clears them and drops the line. A flag raised in the same cycle as that read is kept.

Top module: `rtc_regbank`

## Requirements
- R1: A write to port address 0 stores bits 6:0 of the data as the location index. A read from port address 0 returns 0xFF.
- R2: A write to port address 1 stores the byte at the indexed location, and a read from port address 1 returns it. This applies to the alarm bytes (locations 1, 3, 5) and to plain storage (locations 14 to 127).
- R3: A write to register A (location 10) keeps bit 7, the update-in-progress flag, at its old value and stores bits 6:0. An update-begin strobe sets bit 7 while register B bit 7 (SET) is 0. An update-end strobe clears bit 7.
- R4: A write to register B (location 11) with bit 7 (SET) at 1 stores bit 4 (UIE) as 0 and clears bit 7 of register A. While SET is 1, an update-begin strobe leaves register A bit 7 at 0.
- R5: Writes to register C (location 12) and register D (location 13) change neither register.
- R6: A read of register C returns its current value. The register is then 0x00 and the interrupt output is low from the next cycle, unless a new event arrives in that same cycle.
- R7: An update-end strobe with register B bit 5 (AIE) at 1 sets register C bits 7 and 5 and raises the interrupt when all three alarm bytes match. Alarm location 1 is compared with the current second, 3 with the minute and 5 with the hour. An alarm byte whose bits 7:6 are both 1 matches any value.
- R8: Every update-end strobe sets register C bit 4 (UF). Bit 7 (IRQF) is set and the interrupt raised only when register B bit 4 (UIE) is 1.
- R9: A periodic tick with register B bit 6 (PIE) at 1 sets register C bits 6 and 7 and raises the interrupt. With PIE at 0 the tick changes nothing.
- R10: When a read of register C and a flag event fall in the same cycle, the read returns the old flags and the new flags remain set afterwards.
- R11: After power-on reset, registers A, B, C and D read 0x26, 0x02, 0x00 and 0x80, and the interrupt output is low.
- R12: A soft reset clears register B bits 6, 5 and 3 and keeps its other bits. It clears register C and drops the interrupt.
- R13: An update-end strobe with SET at 0 copies the current second, minute and hour into locations 0, 2 and 4. With SET at 1 those locations are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; loads the power-up values |
| rst_n | input | 1 | Synchronous soft reset, active low; clears enables and flags |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe; a register C read clears the flags at the edge |
| bus_addr | input | 1 | Port select: 0 index port, 1 data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected port, valid in the strobe cycle |
| upd_begin | input | 1 | Calendar update-begin strobe |
| upd_end | input | 1 | Calendar update-end strobe |
| tick | input | 1 | Periodic rate tick |
| cur_sec | input | 8 | Current second, in register encoding |
| cur_min | input | 8 | Current minute, in register encoding |
| cur_hour | input | 8 | Current hour, in register encoding |
| cfg_a | output | 8 | Register A contents for the neighbours |
| cfg_b | output | 8 | Register B contents for the neighbours |
| irq | output | 1 | Interrupt request, active high, registered |

## Verification
The bench targets the collision of a register C read with a new tick or update-end. A bank that applied the clear after the set would lose that event, so the interrupt would stay low and the later read would return zero. It checks that the update-in-progress bit survives writes to register A, and that the SET bit both strips UIE and blocks update-begin; a bank that stored the written byte unmasked would show those bits set. It checks that don't-care alarm bytes match any value while an exact byte one count off does not, and that soft reset clears only the three enables in register B. Random runs mix enable patterns and same-cycle strobes and compare every register C read with flags computed in the bench.

// File: rtl/rtc_regbank_pkg.sv
package rtc_regbank_pkg;

    // fixed locations
    localparam int RTC_IDX_SEC    = 0;
    localparam int RTC_IDX_SEC_AL = 1;
    localparam int RTC_IDX_MIN    = 2;
    localparam int RTC_IDX_MIN_AL = 3;
    localparam int RTC_IDX_HR     = 4;
    localparam int RTC_IDX_HR_AL  = 5;
    localparam int RTC_IDX_A      = 10;
    localparam int RTC_IDX_B      = 11;
    localparam int RTC_IDX_C      = 12;
    localparam int RTC_IDX_D      = 13;

    // register A
    localparam int A_UIP = 7;

    // register B
    localparam int B_SET  = 7;
    localparam int B_PIE  = 6;
    localparam int B_AIE  = 5;
    localparam int B_UIE  = 4;
    localparam int B_SQWE = 3;

    // register C
    localparam int C_IRQF = 7;
    localparam int C_PF   = 6;
    localparam int C_AF   = 5;
    localparam int C_UF   = 4;

    // power-up contents
    localparam logic [7:0] POR_A = 8'h26;
    localparam logic [7:0] POR_B = 8'h02;
    localparam logic [7:0] POR_C = 8'h00;
    localparam logic [7:0] POR_D = 8'h80;

    // bits of B cleared by soft reset
    localparam logic [7:0] B_SOFT_CLR = 8'((1 << B_PIE) | (1 << B_AIE) | (1 << B_SQWE));

    // an alarm byte with both top bits set matches anything
    function automatic logic alarm_field_hit(input logic [7:0] alarm_byte,
                                             input logic [7:0] now_byte);
        return (alarm_byte[7:6] == 2'b11) || (alarm_byte == now_byte);
    endfunction

endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_regbank_pkg::*;
#(
    parameter int NFIELD = 3,
    parameter int DW     = 8
) (
    input  logic [NFIELD-1:0][DW-1:0] alarm_bytes,
    input  logic [NFIELD-1:0][DW-1:0] now_bytes,
    output logic                      all_hit
);

    logic [NFIELD-1:0] field_hit;

    for (genvar f = 0; f < NFIELD; f++) begin : g_field
        always_comb begin
            field_hit[f] = alarm_field_hit(alarm_bytes[f], now_bytes[f]);
        end
    end

    always_comb begin
        all_hit = &field_hit;
    end

endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
    import rtc_regbank_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] flags_q,
    input  logic          rd_clear,
    input  logic          soft_clr,
    input  logic          upd_end,
    input  logic          alarm_hit,
    input  logic          tick,
    input  logic          en_pie,
    input  logic          en_aie,
    input  logic          en_uie,
    output logic [DW-1:0] flags_d
);

    logic [DW-1:0] base;
    logic [DW-1:0] set_mask;

    always_comb begin
        // clear-on-read happens first so a same-cycle event survives
        base     = rd_clear ? '0 : flags_q;
        set_mask = '0;
        if (upd_end) begin
            set_mask[C_UF] = 1'b1;
            if (en_uie) begin
                set_mask[C_IRQF] = 1'b1;
            end
            if (en_aie && alarm_hit) begin
                set_mask[C_AF]   = 1'b1;
                set_mask[C_IRQF] = 1'b1;
            end
        end
        if (tick && en_pie) begin
            set_mask[C_PF]   = 1'b1;
            set_mask[C_IRQF] = 1'b1;
        end
        flags_d = soft_clr ? '0 : (base | set_mask);
    end

endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
    import rtc_regbank_pkg::*;
#(
    parameter int LOC_N = 128,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic          bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          upd_begin,
    input  logic          upd_end,
    input  logic          tick,
    input  logic [DW-1:0] cur_sec,
    input  logic [DW-1:0] cur_min,
    input  logic [DW-1:0] cur_hour,
    output logic [DW-1:0] cfg_a,
    output logic [DW-1:0] cfg_b,
    output logic          irq
);

    localparam int IDX_W   = $clog2(LOC_N);
    localparam int NALARM  = 3;

    typedef logic [IDX_W-1:0] idx_t;

    localparam idx_t IDX_A = idx_t'(RTC_IDX_A);
    localparam idx_t IDX_B = idx_t'(RTC_IDX_B);
    localparam idx_t IDX_C = idx_t'(RTC_IDX_C);
    localparam idx_t IDX_D = idx_t'(RTC_IDX_D);

    typedef struct packed {
        logic [LOC_N-1:0][DW-1:0] mem;
        idx_t                     idx;
        logic                     irq;
    } state_t;

    state_t st_d, st_q;

    logic                     rd_c;
    logic                     set_mode;
    logic                     alarm_hit;
    logic [DW-1:0]            flags_next;
    logic [NALARM-1:0][DW-1:0] alarm_bytes;
    logic [NALARM-1:0][DW-1:0] now_bytes;

    // register views shared with neighbours and the checker
    logic [DW-1:0] reg_a_q, reg_b_q, reg_c_q, reg_d_q;
    idx_t          idx_q;

    always_comb begin
        reg_a_q = st_q.mem[RTC_IDX_A];
        reg_b_q = st_q.mem[RTC_IDX_B];
        reg_c_q = st_q.mem[RTC_IDX_C];
        reg_d_q = st_q.mem[RTC_IDX_D];
        idx_q   = st_q.idx;
    end

    always_comb begin
        alarm_bytes = {st_q.mem[RTC_IDX_HR_AL], st_q.mem[RTC_IDX_MIN_AL], st_q.mem[RTC_IDX_SEC_AL]};
        now_bytes   = {cur_hour, cur_min, cur_sec};
    end

    rtc_alarm_match #(
        .NFIELD (NALARM),
        .DW     (DW)
    ) u_alarm (
        .alarm_bytes (alarm_bytes),
        .now_bytes   (now_bytes),
        .all_hit     (alarm_hit)
    );

    always_comb begin
        rd_c = bus_rd && bus_addr && (st_q.idx == IDX_C);
    end

    rtc_irq_flags #(
        .DW (DW)
    ) u_flags (
        .flags_q   (st_q.mem[RTC_IDX_C]),
        .rd_clear  (rd_c),
        .soft_clr  (!rst_n),
        .upd_end   (upd_end),
        .alarm_hit (alarm_hit),
        .tick      (tick),
        .en_pie    (st_q.mem[RTC_IDX_B][B_PIE]),
        .en_aie    (st_q.mem[RTC_IDX_B][B_AIE]),
        .en_uie    (st_q.mem[RTC_IDX_B][B_UIE]),
        .flags_d   (flags_next)
    );

    // next-state computation
    always_comb begin
        st_d     = st_q;
        set_mode = 1'b0;

        // bus stage
        if (bus_wr) begin
            if (!bus_addr) begin
                st_d.idx = bus_wdata[IDX_W-1:0];
            end else if (st_q.idx == IDX_A) begin
                st_d.mem[RTC_IDX_A] = {st_q.mem[RTC_IDX_A][A_UIP], bus_wdata[A_UIP-1:0]};
            end else if (st_q.idx == IDX_B) begin
                if (bus_wdata[B_SET]) begin
                    st_d.mem[RTC_IDX_B]        = bus_wdata & ~(DW'(1) << B_UIE);
                    st_d.mem[RTC_IDX_A][A_UIP] = 1'b0;
                end else begin
                    st_d.mem[RTC_IDX_B] = bus_wdata;
                end
            end else if ((st_q.idx == IDX_C) || (st_q.idx == IDX_D)) begin
                st_d.mem = st_q.mem;
            end else begin
                st_d.mem[st_q.idx] = bus_wdata;
            end
        end

        // calendar stage
        set_mode = st_d.mem[RTC_IDX_B][B_SET];
        if (upd_begin && !set_mode) begin
            st_d.mem[RTC_IDX_A][A_UIP] = 1'b1;
        end
        if (upd_end) begin
            st_d.mem[RTC_IDX_A][A_UIP] = 1'b0;
            if (!set_mode) begin
                st_d.mem[RTC_IDX_SEC] = cur_sec;
                st_d.mem[RTC_IDX_MIN] = cur_min;
                st_d.mem[RTC_IDX_HR]  = cur_hour;
            end
        end

        // flag stage
        st_d.mem[RTC_IDX_C] = flags_next;
        if (!rst_n) begin
            st_d.mem[RTC_IDX_B] = st_d.mem[RTC_IDX_B] & ~B_SOFT_CLR;
        end
        st_d.irq = flags_next[C_IRQF];
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q                <= '0;
            st_q.mem[RTC_IDX_A] <= POR_A;
            st_q.mem[RTC_IDX_B] <= POR_B;
            st_q.mem[RTC_IDX_C] <= POR_C;
            st_q.mem[RTC_IDX_D] <= POR_D;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = bus_addr ? st_q.mem[st_q.idx] : {DW{1'b1}};
        cfg_a     = st_q.mem[RTC_IDX_A];
        cfg_b     = st_q.mem[RTC_IDX_B];
        irq       = st_q.irq;
    end

endmodule

// File: rtl/rtc_regbank_chk.sv
module rtc_regbank_chk #(
    parameter int IDX_W = 7
) (
    input logic             clk,
    input logic             por_n,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic             bus_addr,
    input logic [7:0]       bus_wdata,
    input logic             upd_begin,
    input logic             upd_end,
    input logic             tick,
    input logic             irq,
    input logic [7:0]       reg_a,
    input logic [7:0]       reg_b,
    input logic [7:0]       reg_c,
    input logic [7:0]       reg_d,
    input logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] LOC_A = IDX_W'(10);
    localparam logic [IDX_W-1:0] LOC_B = IDX_W'(11);
    localparam logic [IDX_W-1:0] LOC_C = IDX_W'(12);

    // R6
    c_read_drops_irq_chk: assert property (@(posedge clk) disable iff (!por_n)
        (bus_rd && bus_addr && idx == LOC_C && !upd_end && !tick) |=> !irq);

    // R3
    uip_kept_on_a_write_chk: assert property (@(posedge clk) disable iff (!por_n)
        (bus_wr && bus_addr && idx == LOC_A && !upd_begin && !upd_end) |=> (reg_a[7] == $past(reg_a[7])));

    // R4
    set_forces_uie_low_chk: assert property (@(posedge clk) disable iff (!por_n)
        (bus_wr && bus_addr && idx == LOC_B && bus_wdata[7]) |=> (!reg_b[4] && !reg_a[7]));

    // R5
    reg_d_fixed_chk: assert property (@(posedge clk) disable iff (!por_n)
        bus_wr |=> $stable(reg_d));

    // R8
    uf_after_update_chk: assert property (@(posedge clk) disable iff (!por_n)
        (upd_end && rst_n) |=> reg_c[4]);

    // R9
    periodic_sets_pf_chk: assert property (@(posedge clk) disable iff (!por_n)
        (tick && reg_b[6] && rst_n) |=> (reg_c[6] && irq));

endmodule

bind rtc_regbank rtc_regbank_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .upd_begin (upd_begin),
    .upd_end   (upd_end),
    .tick      (tick),
    .irq       (irq),
    .reg_a     (reg_a_q),
    .reg_b     (reg_b_q),
    .reg_c     (reg_c_q),
    .reg_d     (reg_d_q),
    .idx       (idx_q)
);

// File: tb/tb_rtc_regbank.sv
module tb_rtc_regbank;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       upd_begin = 1'b0;
    logic       upd_end = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] cur_sec = 8'h05;
    logic [7:0] cur_min = 8'h30;
    logic [7:0] cur_hour = 8'h12;
    logic [7:0] cfg_a, cfg_b;
    logic       irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_regbank dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .upd_begin(upd_begin), .upd_end(upd_end), .tick(tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cfg_a(cfg_a), .cfg_b(cfg_b), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic port_wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic port_rd(input logic a, output logic [7:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic reg_wr(input logic [6:0] i, input logic [7:0] d);
        port_wr(1'b0, {1'b0, i});
        port_wr(1'b1, d);
    endtask

    task automatic reg_rd(input logic [6:0] i, output logic [7:0] v);
        port_wr(1'b0, {1'b0, i});
        port_rd(1'b1, v);
    endtask

    // strobes: bit0 upd_begin, bit1 upd_end, bit2 tick
    task automatic strobe(input logic [2:0] s);
        @(negedge clk);
        upd_begin = s[0]; upd_end = s[1]; tick = s[2];
        @(negedge clk);
        upd_begin = 1'b0; upd_end = 1'b0; tick = 1'b0;
    endtask

    function automatic logic [7:0] exp_flags(input logic [7:0] b, input logic upd,
                                             input logic tk, input logic hit);
        logic [7:0] c = 8'h00;
        if (upd) begin
            c[4] = 1'b1;
            if (b[4]) c[7] = 1'b1;
            if (b[5] && hit) begin c[5] = 1'b1; c[7] = 1'b1; end
        end
        if (tk && b[6]) begin c[6] = 1'b1; c[7] = 1'b1; end
        return c;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got 0x00 expected 0x01");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        logic [7:0] stored [128];
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        por_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);

        // R11 power-up values
        check("R11 irq", {7'd0, irq}, 8'h00);
        reg_rd(7'd10, v); check("R11 A", v, 8'h26);
        reg_rd(7'd11, v); check("R11 B", v, 8'h02);
        reg_rd(7'd12, v); check("R11 C", v, 8'h00);
        reg_rd(7'd13, v); check("R11 D", v, 8'h80);

        // R1 index port
        port_rd(1'b0, v); check("R1 even read", v, 8'hFF);
        port_wr(1'b0, 8'h8E);
        port_wr(1'b1, 8'h33);
        reg_rd(7'd14, v); check("R1 index masked", v, 8'h33);

        // R2 random storage and alarm bytes
        for (int i = 14; i < 128; i++) stored[i] = 8'h00;
        stored[14] = 8'h33;
        for (int k = 0; k < 40; k++) begin
            logic [6:0] ix = 7'(14 + ($urandom % 114));
            logic [7:0] dv = 8'($urandom);
            reg_wr(ix, dv);
            stored[ix] = dv;
        end
        for (int i = 14; i < 128; i += 7) begin
            reg_rd(7'(i), v); check("R2 storage", v, stored[i]);
        end
        reg_wr(7'd3, 8'h4D);
        reg_rd(7'd3, v); check("R2 alarm byte", v, 8'h4D);

        // R3 update-in-progress bit
        reg_wr(7'd10, 8'hFF);
        reg_rd(7'd10, v); check("R3 UIP kept low", v, 8'h7F);
        reg_wr(7'd10, 8'h26);
        strobe(3'b001);
        reg_rd(7'd10, v); check("R3 UIP set by begin", v, 8'hA6);
        reg_wr(7'd10, 8'h26);
        reg_rd(7'd10, v); check("R3 UIP kept high", v, 8'hA6);
        strobe(3'b010);
        reg_rd(7'd10, v); check("R3 UIP cleared by end", v, 8'h26);
        // R13 copy with SET=0
        reg_rd(7'd0, v); check("R13 sec copied", v, 8'h05);
        reg_rd(7'd2, v); check("R13 min copied", v, 8'h30);
        reg_rd(7'd4, v); check("R13 hour copied", v, 8'h12);
        // R8 UF without UIE
        check("R8 no irq without UIE", {7'd0, irq}, 8'h00);
        reg_rd(7'd12, v); check("R8 UF only", v, 8'h10);

        // R4 SET bit
        strobe(3'b001);
        reg_wr(7'd11, 8'h92);
        reg_rd(7'd11, v); check("R4 UIE forced low", v, 8'h82);
        reg_rd(7'd10, v); check("R4 UIP cleared", v, 8'h26);
        strobe(3'b001);
        reg_rd(7'd10, v); check("R4 begin blocked in SET", v, 8'h26);
        cur_sec = 8'h59;
        strobe(3'b010);
        reg_rd(7'd0, v); check("R13 no copy in SET", v, 8'h05);
        reg_rd(7'd12, v); check("R8 UF in SET", v, 8'h10);
        reg_wr(7'd11, 8'h02);
        cur_sec = 8'h05;

        // R5 C and D not writable
        reg_wr(7'd12, 8'hF0);
        reg_rd(7'd12, v); check("R5 C write ignored", v, 8'h00);
        reg_wr(7'd13, 8'h00);
        reg_rd(7'd13, v); check("R5 D write ignored", v, 8'h80);

        // R8 / R6 with UIE
        reg_wr(7'd11, 8'h12);
        strobe(3'b010);
        check("R8 irq with UIE", {7'd0, irq}, 8'h01);
        reg_rd(7'd12, v); check("R6 read returns flags", v, 8'h90);
        check("R6 irq dropped", {7'd0, irq}, 8'h00);
        reg_rd(7'd12, v); check("R6 cleared", v, 8'h00);

        // R7 alarm
        reg_wr(7'd11, 8'h22);
        reg_wr(7'd1, 8'hC0);
        reg_wr(7'd3, 8'h30);
        reg_wr(7'd5, 8'h12);
        strobe(3'b010);
        check("R7 irq on match", {7'd0, irq}, 8'h01);
        reg_rd(7'd12, v); check("R7 flags on match", v, 8'hB0);
        cur_min = 8'h31;
        strobe(3'b010);
        check("R7 no irq on mismatch", {7'd0, irq}, 8'h00);
        reg_rd(7'd12, v); check("R7 flags on mismatch", v, 8'h10);
        cur_min = 8'h30;
        reg_wr(7'd11, 8'h02);
        strobe(3'b010);
        reg_rd(7'd12, v); check("R7 AIE off", v, 8'h10);

        // R9 periodic
        reg_wr(7'd11, 8'h42);
        strobe(3'b100);
        check("R9 irq on tick", {7'd0, irq}, 8'h01);
        reg_rd(7'd12, v); check("R9 PF flags", v, 8'hC0);
        reg_wr(7'd11, 8'h02);
        strobe(3'b100);
        check("R9 tick ignored irq", {7'd0, irq}, 8'h00);
        reg_rd(7'd12, v); check("R9 tick ignored flags", v, 8'h00);

        // R10 read and event in the same cycle
        reg_wr(7'd11, 8'h42);
        strobe(3'b100);
        port_wr(1'b0, 8'h0C);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 1'b1; tick = 1'b1;
        #1 v = bus_rdata;
        check("R10 read returns old", v, 8'hC0);
        @(negedge clk);
        bus_rd = 1'b0; tick = 1'b0;
        check("R10 irq survives", {7'd0, irq}, 8'h01);
        reg_rd(7'd12, v); check("R10 flag survives", v, 8'hC0);
        reg_wr(7'd11, 8'h02);
        port_wr(1'b0, 8'h0C);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 1'b1; upd_end = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; upd_end = 1'b0;
        reg_rd(7'd12, v); check("R10 UF survives", v, 8'h10);

        // R12 soft reset
        reg_wr(7'd11, 8'h7E);
        strobe(3'b100);
        check("R12 irq before", {7'd0, irq}, 8'h01);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R12 irq dropped", {7'd0, irq}, 8'h00);
        reg_rd(7'd11, v); check("R12 B enables cleared", v, 8'h16);
        reg_rd(7'd12, v); check("R12 C cleared", v, 8'h00);

        // random mix of enables and same-cycle strobes
        reg_wr(7'd1, 8'hC0);
        reg_wr(7'd5, 8'hFF);
        for (int k = 0; k < 30; k++) begin
            logic [7:0] bv = 8'h02 | (8'($urandom) & 8'h70);
            logic       up = 1'($urandom);
            logic       tk = 1'($urandom);
            logic [7:0] am = ($urandom % 2) ? 8'hC0 : 8'h30;
            logic [7:0] ec;
            cur_min = ($urandom % 2) ? 8'h30 : 8'h31;
            reg_wr(7'd3, am);
            reg_wr(7'd11, bv);
            strobe({tk, up, 1'b0});
            ec = exp_flags(bv, up, tk, (am == 8'hC0) || (cur_min == 8'h30));
            check("R7/R8/R9 random irq", {7'd0, irq}, {7'd0, ec[7]});
            reg_rd(7'd12, v); check("R7/R8/R9 random flags", v, ec);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule